// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the bus master that carries out one write-type operation on a parallel NOR flash device: a single-word program, a sector erase, or setting or clearing a sector lock. A vendor code chooses one of two command dialects. The first is a status-register dialect, which finishes when a status bit is set. The second is an unlock-cycle dialect, which finishes when a data bit stops toggling. The block first issues the bus writes that the chosen operation needs. It then polls the device until the operation completes or a millisecond-based timeout expires. Last, it reduces what it saw to a single result code.

Software or a higher-level controller starts an operation with a one-cycle request. The request carries the operation kind, the vendor code, a sector base address, a destination word address, a data word and a timeout in milliseconds. While the operation runs, `busy` stays high. At the end, `done` pulses for one cycle together with a valid `result`. Each bus access is one clock cycle: a write asserts `busWe`, and a read asserts `busOe` and takes `busRdata` at the end of that cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `busWe`, `busOe` and `done` are low.
- R2: A sector erase in the status dialect (vendor code 1 or 3, `opKind`=1) writes 0x50, 0x20, 0xD0 at the sector base. When the device completes, the block then writes 0xFF at the sector base.
- R3: A sector erase in the unlock dialect (vendor code 2 or 4) writes six words in this order: 0xAA at word 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, and 0x30 at the sector base.
- R4: A word program (`opKind`=0) writes the data word to the destination as its last command write. In the status dialect it writes 0x50 and then 0x40 at the destination first. In the unlock dialect it writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555 first.
- R5: Before a program, the block reads the destination. If (read & data) != data, it finishes with result 2 (not erased) and performs no bus write.
- R6: In the status dialect, the block polls the read word until bit 7 is set. If the status byte then equals exactly 0x80, the result is 0 (OK).
- R7: A completed status byte other than 0x80 is classified in this order. Bit 1 set gives result 3 (protected). Otherwise, bit 5 set with bit 4 clear gives result 2 (not erased). Otherwise the result is 4 (invalid/sequence error). In every case the block then writes 0xFF.
- R8: In the unlock dialect, the block reads in pairs. It finishes with result 0 when bit 6 matches across two back-to-back reads, and it writes no reset command afterwards.
- R9: Polling that outlasts `toutMs` milliseconds ends with result 1. The block first writes the reset command (0xFF in the status dialect, 0xF0 in the unlock dialect). The elapsed time from the last command write to `done` is at least (`toutMs`+1)·`TICKS_PER_MS` cycles.
- R10: A lock operation in the status dialect writes 0x50, 0x60 and then 0x01 at the sector base. An unlock operation (`opKind`=3) writes 0xD0 in place of 0x01. A lock operation is `opKind`=2.
- R11: Any vendor code other than 1–4, and any lock or unlock request in the unlock dialect, ends with result 4 and performs no bus access.
- R12: `done` is a one-cycle pulse given while `busy` is high. Requests made while `busy` is high are ignored, and `busWe` and `busOe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | One-cycle operation request, taken only when idle |
| opKind | input | 2 | 0 program, 1 erase, 2 lock, 3 unlock |
| vendor | input | VW | Command-set vendor code |
| sectorAddr | input | AW | Sector base word address |
| destAddr | input | AW | Program destination word address |
| wrData | input | DW | Word to program |
| toutMs | input | TW | Polling timeout in milliseconds |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 OK, 1 timeout, 2 not erased, 3 protected, 4 invalid |
| busAddr | output | AW | Flash word address |
| busWdata | output | DW | Flash write data |
| busWe | output | 1 | Write strobe, one cycle per write |
| busOe | output | 1 | Read strobe, one cycle per read |
| busRdata | input | DW | Flash read data, sampled at the end of a read cycle |

## Verification
The bench builds the block with `TICKS_PER_MS`=4, a 12-bit address, a 16-bit data word and an 8-bit timeout field. With these values, a timeout of two milliseconds expires after about a dozen polling cycles. This keeps both the status-dialect timeout and the toggle-dialect timeout inside short directed runs. It also lets the bench check the lower bound on elapsed cycles exactly. The 12-bit address still holds both unlock offsets, and the 16-bit word shows that commands occupy only the low byte while program data uses the full width.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_ERASE = 2'd1, OP_LOCK = 2'd2, OP_UNLOCK = 2'd3} opKind_e;
  typedef enum logic [1:0] {AS_SECT = 2'd0, AS_UNL1 = 2'd1, AS_UNL2 = 2'd2, AS_DEST = 2'd3} addrSel_e;

  localparam logic [2:0] RES_OK         = 3'd0;
  localparam logic [2:0] RES_TIMEOUT    = 3'd1;
  localparam logic [2:0] RES_NOT_ERASED = 3'd2;
  localparam logic [2:0] RES_PROTECTED  = 3'd3;
  localparam logic [2:0] RES_INVALID    = 3'd4;

  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET    = 8'h01;
  localparam logic [7:0] CMD_LOCK_CLR    = 8'hD0;
  localparam logic [7:0] CMD_READ_MODE   = 8'hFF;
  localparam logic [7:0] CMD_UNL_A       = 8'hAA;
  localparam logic [7:0] CMD_UNL_B       = 8'h55;
  localparam logic [7:0] CMD_UNL_PROG    = 8'hA0;
  localparam logic [7:0] CMD_UNL_ERASE   = 8'h80;
  localparam logic [7:0] CMD_UNL_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_UNL_RESET   = 8'hF0;

  typedef struct packed {
    logic       latch;
    logic       busWr;
    logic       busRd;
    addrSel_e   addrSel;
    logic       useData;
    logic [7:0] cmdByte;
    logic       tmrClr;
    logic       tmrRun;
    logic       capToggle;
    logic       resLoad;
    logic [2:0] resCode;
  } ctrlStb_t;

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [1:0]    opKind,
  input  logic [VW-1:0] vendor,
  input  logic          rdNotErased,
  input  logic          rdDoneBit,
  input  logic [2:0]    rdStatClass,
  input  logic          rdToggleSame,
  input  logic          timedOut,
  output ctrlStb_t      stb,
  output logic          busy,
  output logic          done
);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_CMD, S_POLL, S_TOG1, S_TOG2, S_RST, S_DONE
  } state_e;

  state_e     state, stateNx;
  logic [2:0] stepQ, stepNx;
  opKind_e    kindQ, kindNx;
  logic       togQ, togNx;

  logic reqStat, reqTog, reqBad;
  opKind_e reqKind;
  assign reqKind = opKind_e'(opKind);
  assign reqStat = (vendor == VW'(1)) || (vendor == VW'(3));
  assign reqTog  = (vendor == VW'(2)) || (vendor == VW'(4));
  assign reqBad  = !(reqStat || reqTog) ||
                   (reqTog && (reqKind == OP_LOCK || reqKind == OP_UNLOCK));

  // command step decode for the latched operation
  addrSel_e   stAddr;
  logic       stData;
  logic [7:0] stByte;
  logic       stLast;
  addrSel_e   pollAddr;

  assign pollAddr = (kindQ == OP_PROG) ? AS_DEST : AS_SECT;

  always_comb begin
    stAddr = AS_SECT;
    stData = 1'b0;
    stByte = 8'h00;
    stLast = 1'b0;
    if (!togQ) begin
      stAddr = pollAddr;
      stLast = (stepQ == 3'd2);
      case (stepQ)
        3'd0: stByte = CMD_CLR_STATUS;
        3'd1: stByte = (kindQ == OP_PROG)  ? CMD_PROG_SETUP :
                       (kindQ == OP_ERASE) ? CMD_ERASE_SETUP : CMD_LOCK_SETUP;
        default: begin
          stByte = (kindQ == OP_ERASE) ? CMD_ERASE_GO :
                   (kindQ == OP_LOCK)  ? CMD_LOCK_SET : CMD_LOCK_CLR;
          stData = (kindQ == OP_PROG);
        end
      endcase
    end else begin
      stLast = (kindQ == OP_PROG) ? (stepQ == 3'd3) : (stepQ == 3'd5);
      case (stepQ)
        3'd0, 3'd3: begin
          if (kindQ == OP_PROG && stepQ == 3'd3) begin
            stAddr = AS_DEST;
            stData = 1'b1;
          end else begin
            stAddr = AS_UNL1;
            stByte = CMD_UNL_A;
          end
        end
        3'd1, 3'd4: begin
          stAddr = AS_UNL2;
          stByte = CMD_UNL_B;
        end
        3'd2: begin
          stAddr = AS_UNL1;
          stByte = (kindQ == OP_PROG) ? CMD_UNL_PROG : CMD_UNL_ERASE;
        end
        default: begin
          stAddr = AS_SECT;
          stByte = CMD_UNL_SECTOR;
        end
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    stateNx  = state;
    stepNx   = stepQ;
    kindNx   = kindQ;
    togNx    = togQ;
    case (state)
      S_IDLE: begin
        if (opValid) begin
          stb.latch = 1'b1;
          kindNx    = reqKind;
          togNx     = reqTog;
          stepNx    = 3'd0;
          if (reqBad) begin
            stb.resLoad = 1'b1;
            stb.resCode = RES_INVALID;
            stateNx     = S_DONE;
          end else if (reqKind == OP_PROG) begin
            stateNx = S_PRE;
          end else begin
            stateNx = S_CMD;
          end
        end
      end
      S_PRE: begin
        stb.busRd   = 1'b1;
        stb.addrSel = AS_DEST;
        if (rdNotErased) begin
          stb.resLoad = 1'b1;
          stb.resCode = RES_NOT_ERASED;
          stateNx     = S_DONE;
        end else begin
          stateNx = S_CMD;
        end
      end
      S_CMD: begin
        stb.busWr   = 1'b1;
        stb.addrSel = stAddr;
        stb.useData = stData;
        stb.cmdByte = stByte;
        if (stLast) begin
          stb.tmrClr = 1'b1;
          stateNx    = togQ ? S_TOG1 : S_POLL;
        end else begin
          stepNx = stepQ + 3'd1;
        end
      end
      S_POLL: begin
        stb.busRd   = 1'b1;
        stb.addrSel = pollAddr;
        stb.tmrRun  = 1'b1;
        if (rdDoneBit) begin
          stb.resLoad = 1'b1;
          stb.resCode = rdStatClass;
          stateNx     = S_RST;
        end else if (timedOut) begin
          stb.resLoad = 1'b1;
          stb.resCode = RES_TIMEOUT;
          stateNx     = S_RST;
        end
      end
      S_TOG1: begin
        stb.busRd     = 1'b1;
        stb.addrSel   = pollAddr;
        stb.tmrRun    = 1'b1;
        stb.capToggle = 1'b1;
        stateNx       = S_TOG2;
      end
      S_TOG2: begin
        stb.busRd   = 1'b1;
        stb.addrSel = pollAddr;
        stb.tmrRun  = 1'b1;
        if (rdToggleSame) begin
          stb.resLoad = 1'b1;
          stb.resCode = RES_OK;
          stateNx     = S_DONE;
        end else if (timedOut) begin
          stb.resLoad = 1'b1;
          stb.resCode = RES_TIMEOUT;
          stateNx     = S_RST;
        end else begin
          stateNx = S_TOG1;
        end
      end
      S_RST: begin
        stb.busWr   = 1'b1;
        stb.addrSel = pollAddr;
        stb.cmdByte = togQ ? CMD_UNL_RESET : CMD_READ_MODE;
        stateNx     = S_DONE;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      stepQ <= 3'd0;
      kindQ <= OP_PROG;
      togQ  <= 1'b0;
    end else begin
      state <= stateNx;
      stepQ <= stepNx;
      kindQ <= kindNx;
      togQ  <= togNx;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int AW           = 24,
  parameter int DW           = 16,
  parameter int TW           = 16,
  parameter int TICKS_PER_MS = 100000,
  parameter int UNL1_OFS     = 'h555,
  parameter int UNL2_OFS     = 'h2AA
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStb_t      stb,
  input  logic [AW-1:0] sectorAddr,
  input  logic [AW-1:0] destAddr,
  input  logic [DW-1:0] wrData,
  input  logic [TW-1:0] toutMs,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          busWe,
  output logic          busOe,
  output logic [2:0]    result,
  output logic          rdNotErased,
  output logic          rdDoneBit,
  output logic [2:0]    rdStatClass,
  output logic          rdToggleSame,
  output logic          timedOut
);

  localparam int TCK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [TCK_W-1:0] TCK_LAST = TCK_W'(TICKS_PER_MS - 1);
  localparam logic [AW-1:0] UNL1_ADDR = AW'(UNL1_OFS);
  localparam logic [AW-1:0] UNL2_ADDR = AW'(UNL2_OFS);

  logic [AW-1:0]    sectQ, destQ;
  logic [DW-1:0]    dataQ;
  logic [TW-1:0]    toutQ;
  logic [TCK_W-1:0] tickCnt;
  logic [TW:0]      msCnt;
  logic             prevBit6;
  logic [2:0]       resQ;
  logic [7:0]       statByte;

  always_comb begin
    case (stb.addrSel)
      AS_SECT: busAddr = sectQ;
      AS_UNL1: busAddr = UNL1_ADDR;
      AS_UNL2: busAddr = UNL2_ADDR;
      default: busAddr = destQ;
    endcase
  end

  assign busWdata = stb.useData ? dataQ : {{(DW-8){1'b0}}, stb.cmdByte};
  assign busWe    = stb.busWr;
  assign busOe    = stb.busRd;
  assign result   = resQ;

  // read-side flags
  assign statByte     = busRdata[7:0];
  assign rdNotErased  = (busRdata & dataQ) != dataQ;
  assign rdDoneBit    = statByte[7];
  assign rdToggleSame = (busRdata[6] == prevBit6);
  assign timedOut     = (msCnt > {1'b0, toutQ});

  always_comb begin
    if (statByte == 8'h80)              rdStatClass = RES_OK;
    else if (statByte[1])               rdStatClass = RES_PROTECTED;
    else if (statByte[5] && !statByte[4]) rdStatClass = RES_NOT_ERASED;
    else                                rdStatClass = RES_INVALID;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectQ    <= '0;
      destQ    <= '0;
      dataQ    <= '0;
      toutQ    <= '0;
      tickCnt  <= '0;
      msCnt    <= '0;
      prevBit6 <= 1'b0;
      resQ     <= RES_OK;
    end else begin
      if (stb.latch) begin
        sectQ <= sectorAddr;
        destQ <= destAddr;
        dataQ <= wrData;
        toutQ <= toutMs;
      end
      if (stb.tmrClr) begin
        tickCnt <= '0;
        msCnt   <= '0;
      end else if (stb.tmrRun) begin
        if (tickCnt == TCK_LAST) begin
          tickCnt <= '0;
          if (msCnt != '1) msCnt <= msCnt + 1'b1;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
      if (stb.capToggle) prevBit6 <= busRdata[6];
      if (stb.resLoad)   resQ <= stb.resCode;
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW           = 24,
  parameter int DW           = 16,
  parameter int TW           = 16,
  parameter int VW           = 16,
  parameter int TICKS_PER_MS = 100000,
  parameter int UNL1_OFS     = 'h555,
  parameter int UNL2_OFS     = 'h2AA
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [1:0]    opKind,
  input  logic [VW-1:0] vendor,
  input  logic [AW-1:0] sectorAddr,
  input  logic [AW-1:0] destAddr,
  input  logic [DW-1:0] wrData,
  input  logic [TW-1:0] toutMs,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          busWe,
  output logic          busOe,
  input  logic [DW-1:0] busRdata
);

  ctrlStb_t   stb;
  logic       rdNotErased, rdDoneBit, rdToggleSame, timedOut;
  logic [2:0] rdStatClass;

  nor_seq_ctrl #(.VW(VW)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .vendor(vendor),
    .rdNotErased(rdNotErased), .rdDoneBit(rdDoneBit), .rdStatClass(rdStatClass),
    .rdToggleSame(rdToggleSame), .timedOut(timedOut),
    .stb(stb), .busy(busy), .done(done)
  );

  nor_seq_dp #(
    .AW(AW), .DW(DW), .TW(TW), .TICKS_PER_MS(TICKS_PER_MS),
    .UNL1_OFS(UNL1_OFS), .UNL2_OFS(UNL2_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sectorAddr(sectorAddr), .destAddr(destAddr), .wrData(wrData), .toutMs(toutMs),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busOe(busOe), .result(result),
    .rdNotErased(rdNotErased), .rdDoneBit(rdDoneBit), .rdStatClass(rdStatClass),
    .rdToggleSame(rdToggleSame), .timedOut(timedOut)
  );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       busWe,
  input logic       busOe,
  input logic [2:0] result
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWe && !busOe && !done)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busOe)); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R12

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R12

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result <= 3'd4)); // R7

endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .busWe(busWe), .busOe(busOe), .result(result)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int TW = 8;
  localparam int VW = 16;
  localparam int TPM = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic [1:0]    opKind = 2'd0;
  logic [VW-1:0] vendor = '0;
  logic [AW-1:0] sectorAddr = '0;
  logic [AW-1:0] destAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [TW-1:0] toutMs = '0;
  logic          busy, done;
  logic [2:0]    result;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic          busWe, busOe;
  logic [DW-1:0] busRdata;

  always #4 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW), .TW(TW), .VW(VW), .TICKS_PER_MS(TPM)) u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .vendor(vendor),
    .sectorAddr(sectorAddr), .destAddr(destAddr), .wrData(wrData), .toutMs(toutMs),
    .busy(busy), .done(done), .result(result), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busOe(busOe), .busRdata(busRdata)
  );

  // flash model configuration (driven by tasks only)
  logic [DW-1:0] mArray = 16'hFFFF;
  logic [DW-1:0] mFinal = 16'h0080;
  logic          mTogStyle = 1'b0;
  int            mBusyN = 0;
  int            wrBase = 0;
  int            pollBase = 0;

  // model/monitor state (driven by always blocks only)
  int            wrCount = 0;
  int            pollRd = 0;
  int            cyc = 0;
  int            doneCnt = 0;
  int            doneCyc = 0;
  logic [2:0]    resAtDone = 3'd0;
  logic [AW-1:0] logA [64];
  logic [DW-1:0] logD [64];
  int            logC [64];

  logic pollBusy;
  assign pollBusy = (pollRd - pollBase) < mBusyN;
  assign busRdata = (wrCount == wrBase) ? mArray :
                    pollBusy ? (mTogStyle ? (pollRd[0] ? 16'h0040 : 16'h0000) : 16'h0000) :
                    mFinal;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busOe && (wrCount != wrBase)) pollRd <= pollRd + 1;
  end

  always @(negedge clk) begin
    if (busWe) begin
      logA[wrCount % 64] <= busAddr;
      logD[wrCount % 64] <= busWdata;
      logC[wrCount % 64] <= cyc;
      wrCount <= wrCount + 1;
    end
    if (done) begin
      doneCnt   <= doneCnt + 1;
      resAtDone <= result;
      doneCyc   <= cyc;
    end
  end

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkWr(input string req, input int idx, input int expA, input int expD);
    int a = int'(logA[(wrBase + idx) % 64]);
    int d = int'(logD[(wrBase + idx) % 64]);
    chk(a == expA, req, $sformatf("write %0d addr", idx), a, expA);
    chk(d == expD, req, $sformatf("write %0d data", idx), d, expD);
  endtask

  int doneBase = 0;

  task automatic runOp(input int kind, input int vend, input int sect, input int dest,
                       input int data, input int tout, input int busyN,
                       input int finalSt, input bit tog);
    @(negedge clk);
    wrBase    = wrCount;
    pollBase  = pollRd;
    doneBase  = doneCnt;
    mBusyN    = busyN;
    mFinal    = DW'(finalSt);
    mTogStyle = tog;
    opKind    = 2'(kind);
    vendor    = VW'(vend);
    sectorAddr = AW'(sect);
    destAddr  = AW'(dest);
    wrData    = DW'(data);
    toutMs    = TW'(tout);
    opValid   = 1'b1;
    @(negedge clk);
    opValid   = 1'b0;
    for (int i = 0; i < 3000 && doneCnt == doneBase; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(busWe == 1'b0 && busOe == 1'b0, "R1", "strobes after reset", {busWe, busOe}, 0);
  endtask

  task automatic tStatErase();
    runOp(1, 1, 'h400, 0, 0, 10, 3, 'h80, 0);
    chk(wrCount - wrBase == 4, "R2", "write count", wrCount - wrBase, 4);
    chkWr("R2", 0, 'h400, 'h50);
    chkWr("R2", 1, 'h400, 'h20);
    chkWr("R2", 2, 'h400, 'hD0);
    chkWr("R2", 3, 'h400, 'hFF);
    chk(resAtDone == 3'd0, "R6", "erase ok result", resAtDone, 0);
    chk(doneCnt - doneBase == 1, "R12", "done pulses", doneCnt - doneBase, 1);
    chk(busy == 1'b0, "R12", "busy after done", busy, 0);
  endtask

  task automatic tTogErase();
    runOp(1, 2, 'h800, 0, 0, 10, 5, 0, 1);
    chk(wrCount - wrBase == 6, "R3", "write count", wrCount - wrBase, 6);
    chkWr("R3", 0, 'h555, 'hAA);
    chkWr("R3", 1, 'h2AA, 'h55);
    chkWr("R3", 2, 'h555, 'h80);
    chkWr("R3", 3, 'h555, 'hAA);
    chkWr("R3", 4, 'h2AA, 'h55);
    chkWr("R3", 5, 'h800, 'h30);
    chk(resAtDone == 3'd0, "R8", "toggle erase result", resAtDone, 0);
  endtask

  task automatic tStatProg();
    mArray = 16'hFFFF;
    runOp(0, 3, 'h100, 'h123, 'hBEEF, 10, 2, 'h80, 0);
    chk(wrCount - wrBase == 4, "R4", "status program writes", wrCount - wrBase, 4);
    chkWr("R4", 0, 'h123, 'h50);
    chkWr("R4", 1, 'h123, 'h40);
    chkWr("R4", 2, 'h123, 'hBEEF);
    chkWr("R6", 3, 'h123, 'hFF);
    chk(resAtDone == 3'd0, "R6", "program ok result", resAtDone, 0);
  endtask

  task automatic tTogProg();
    mArray = 16'h0FFF;
    runOp(0, 4, 'h100, 'h0AB, 'h0F0F, 10, 4, 0, 1);
    chk(wrCount - wrBase == 4, "R4", "toggle program writes", wrCount - wrBase, 4);
    chkWr("R4", 0, 'h555, 'hAA);
    chkWr("R4", 1, 'h2AA, 'h55);
    chkWr("R4", 2, 'h555, 'hA0);
    chkWr("R4", 3, 'h0AB, 'h0F0F);
    chk(resAtDone == 3'd0, "R8", "toggle program result", resAtDone, 0);
  endtask

  task automatic tNotErased();
    mArray = 16'h00F0;
    runOp(0, 1, 'h100, 'h050, 'h0F0F, 10, 0, 'h80, 0);
    chk(resAtDone == 3'd2, "R5", "not erased result", resAtDone, 2);
    chk(wrCount == wrBase, "R5", "no writes", wrCount - wrBase, 0);
    runOp(0, 2, 'h100, 'h050, 'h0F0F, 10, 0, 0, 1);
    chk(resAtDone == 3'd2, "R5", "not erased result toggle", resAtDone, 2);
    chk(wrCount == wrBase, "R5", "no writes toggle", wrCount - wrBase, 0);
    mArray = 16'hFFFF;
  endtask

  task automatic tClassify(input int st, input int exp);
    runOp(1, 1, 'h200, 0, 0, 10, 2, st, 0);
    chk(int'(resAtDone) == exp, "R7", $sformatf("status 0x%0h class", st), resAtDone, exp);
    chkWr("R7", 3, 'h200, 'hFF);
  endtask

  task automatic tTimeout(input int vend, input bit tog, input int rstCmd);
    int n;
    int el;
    runOp(1, vend, 'h300, 0, 0, 2, 100000, 'h80, tog);
    n = tog ? 7 : 4;
    chk(resAtDone == 3'd1, "R9", "timeout result", resAtDone, 1);
    chk(wrCount - wrBase == n, "R9", "timeout write count", wrCount - wrBase, n);
    chkWr("R9", n - 1, 'h300, rstCmd);
    el = doneCyc - logC[(wrBase + n - 2) % 64];
    chk(el >= 3 * TPM && el <= 3 * TPM + 8, "R9", "timeout elapsed cycles", el, 3 * TPM);
  endtask

  task automatic tLock();
    runOp(2, 1, 'h600, 0, 0, 10, 1, 'h80, 0);
    chkWr("R10", 0, 'h600, 'h50);
    chkWr("R10", 1, 'h600, 'h60);
    chkWr("R10", 2, 'h600, 'h01);
    chk(resAtDone == 3'd0, "R10", "lock result", resAtDone, 0);
    runOp(3, 3, 'h640, 0, 0, 10, 1, 'h80, 0);
    chkWr("R10", 0, 'h640, 'h50);
    chkWr("R10", 1, 'h640, 'h60);
    chkWr("R10", 2, 'h640, 'hD0);
    chk(resAtDone == 3'd0, "R10", "unlock result", resAtDone, 0);
  endtask

  task automatic tInvalid();
    int rd0;
    rd0 = pollRd;
    runOp(1, 7, 'h100, 0, 0, 10, 0, 'h80, 0);
    chk(resAtDone == 3'd4, "R11", "unknown vendor result", resAtDone, 4);
    chk(wrCount == wrBase, "R11", "unknown vendor writes", wrCount - wrBase, 0);
    runOp(2, 2, 'h100, 0, 0, 10, 0, 0, 1);
    chk(resAtDone == 3'd4, "R11", "lock in toggle dialect", resAtDone, 4);
    chk(wrCount == wrBase, "R11", "lock toggle writes", wrCount - wrBase, 0);
    chk(pollRd == rd0, "R11", "no reads", pollRd - rd0, 0);
  endtask

  task automatic tBusyIgnore();
    @(negedge clk);
    wrBase = wrCount;
    pollBase = pollRd;
    doneBase = doneCnt;
    mBusyN = 12;
    mFinal = 16'h0080;
    mTogStyle = 1'b0;
    opKind = 2'd1; vendor = 16'd1; sectorAddr = 12'h700; toutMs = 8'd20;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    repeat (6) @(negedge clk);
    opKind = 2'd0; vendor = 16'd2; sectorAddr = 12'h010; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    for (int i = 0; i < 500 && doneCnt == doneBase; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(doneCnt - doneBase == 1, "R12", "one done for ignored request", doneCnt - doneBase, 1);
    chk(wrCount - wrBase == 4, "R12", "writes unchanged by ignored request", wrCount - wrBase, 4);
    chkWr("R12", 0, 'h700, 'h50);
    chk(resAtDone == 3'd0, "R12", "result of accepted op", resAtDone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStatErase();
    tTogErase();
    tStatProg();
    tTogProg();
    tNotErased();
    tClassify('hB0, 4);
    tClassify('hA0, 2);
    tClassify('h82, 3);
    tClassify('h88, 4);
    tClassify('hB2, 3);
    tTimeout(1, 1'b0, 'hFF);
    tTimeout(4, 1'b1, 'hF0);
    tLock();
    tInvalid();
    tBusyIgnore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule